// File: doc/BRIEF.md
# Channel-Indexed Configuration Register Bank

This block is the configuration store of a ten-channel converter: eight data channels (A to H) and two clock channels (frame clock and data clock). It is reached through a byte-wide register bus with an address, write data, a write strobe, a read strobe and a registered read data byte. Two index registers form a ten-bit channel-select mask. A write to a per-channel register lands in the staging copy of every selected channel at once.

Staged values have no effect on the outputs until software writes the transfer command. One cycle later, every channel's live copy takes its staged value in the same clock. The live power mode, duty-cycle stabilizer enable and test control byte of each channel are brought out as ports. A global port-configuration byte holds a bit-order flag and a soft-reset request. Each of these is stored once and shown in mirrored form in both nibbles of the byte.

Top module: `cfg_bank`

## Requirements
- R1: After rst_ni is released, reads return 0x18 at 0x00, 0x0F at 0x04 and 0x05, 0x00 at 0x08, 0x01 at 0x09, 0x00 at 0x0D and 0x00 at 0xFF. Every channel's live outputs are power mode 000, stabilizer 1 and test byte 0x00.
- R2: Address 0x01 reads the CHIP_ID parameter. Address 0x02 reads {1'b0, CHILD_ID, 4'b0000}, where CHILD_ID 000 marks the faster grade and 001 the slower one. Writes to either address change nothing.
- R3: A write to 0x00 keeps L = wdata[6] and S = wdata[5] and ignores the lower nibble. A read of 0x00 returns {0, L, S, 1, 1, S, L, 0}. lsb_first_o equals L.
- R4: The channel mask is {reg04[5:0], reg05[3:0]}. Mask bits 0 to 3 select channels A to D, bits 4 to 7 select E to H, bit 8 selects the frame clock and bit 9 selects the data clock. A read of 0x04 returns bits 5:0, and a read of 0x05 returns bits 3:0.
- R5: A write to 0x08 (bits 2:0), 0x09 (bit 0) or 0x0D (all 8 bits) updates the staging copy of every selected channel and of no other channel. The live outputs do not change.
- R6: A write to 0xFF with bit 0 set makes 0xFF read 1 until the next clock edge. At that edge, every live copy takes its staged value and the bit clears. A write to 0xFF with bit 0 clear changes nothing.
- R7: A read of 0x08, 0x09 or 0x0D returns the staged value of the lowest-numbered selected channel, zero-extended. If no channel is selected, it returns 0x00.
- R8: A read of any address other than 0x00, 0x01, 0x02, 0x04, 0x05, 0x08, 0x09, 0x0D or 0xFF returns 0x00.
- R9: A write to 0x00 with bit 5 set makes 0x00 show the soft-reset bits for one cycle. At the next edge, every other register, staged and live, returns to its default and the soft-reset bits clear. The bit-order flag is kept.
- R10: A channel write in the same cycle as the transfer copy goes to staging only. The live copy takes the value staged before that write.
- R11: Live channel i drives pwr_mode_o[3i+2:3i], dcs_en_o[i] and test_ctl_o[8i+7:8i], with i numbered as the mask bits of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| addr_i | input | 8 | register address |
| wdata_i | input | 8 | write data |
| wr_i | input | 1 | write strobe |
| rd_i | input | 1 | read strobe; rdata_o updates at the next edge |
| rdata_o | output | 8 | registered read data |
| lsb_first_o | output | 1 | bit-order flag |
| pwr_mode_o | output | 30 | live power mode, 3 bits per channel |
| dcs_en_o | output | 10 | live duty-cycle stabilizer enable per channel |
| test_ctl_o | output | 80 | live test control byte per channel |

## Verification
The transfer copy and a staging write can fall in the same clock. The bench writes the transfer command and then, in the very next cycle, a new test byte to the only selected channel. It then checks that the live output holds the value staged before that write, while a read of the register returns the new value. A second transfer then moves the new value to the output. The soft-reset clear, landing one cycle after its own write, is checked in a similar way: the bit-order flag must survive while the index registers and live copies fall back to their defaults.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;
  localparam int NUM_CH = 10;
  localparam int DW     = 8;

  localparam logic [7:0] A_PORT  = 8'h00;
  localparam logic [7:0] A_ID    = 8'h01;
  localparam logic [7:0] A_GRADE = 8'h02;
  localparam logic [7:0] A_IDXHI = 8'h04;
  localparam logic [7:0] A_IDXLO = 8'h05;
  localparam logic [7:0] A_PWR   = 8'h08;
  localparam logic [7:0] A_CLK   = 8'h09;
  localparam logic [7:0] A_TEST  = 8'h0D;
  localparam logic [7:0] A_XFER  = 8'hFF;

  typedef struct packed {
    logic [2:0]    pwr;
    logic          dcs;
    logic [DW-1:0] test;
  } chan_cfg_t;

  localparam chan_cfg_t CHAN_DEF = '{pwr: 3'b000, dcs: 1'b1, test: '0};
endpackage

// File: rtl/cfg_chan_regs.sv
module cfg_chan_regs
  import cfg_bank_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          sel_i,
  input  logic          wr_pwr_i,
  input  logic          wr_clk_i,
  input  logic          wr_test_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          xfer_i,
  output chan_cfg_t     stage_o,
  output chan_cfg_t     live_o
);
  chan_cfg_t stage_q, live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= CHAN_DEF;
      live_q  <= CHAN_DEF;
    end else if (clr_i) begin
      stage_q <= CHAN_DEF;
      live_q  <= CHAN_DEF;
    end else begin
      if (xfer_i) live_q <= stage_q;  // pre-edge staging value
      if (sel_i) begin
        if (wr_pwr_i)  stage_q.pwr  <= wdata_i[2:0];
        if (wr_clk_i)  stage_q.dcs  <= wdata_i[0];
        if (wr_test_i) stage_q.test <= wdata_i;
      end
    end
  end

  assign stage_o = stage_q;
  assign live_o  = live_q;
endmodule

// File: rtl/cfg_chan_select.sv
module cfg_chan_select #(
  parameter int N = 10,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] mask_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    any_o = |mask_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = W'(i);
    end
  end
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
  import cfg_bank_pkg::*;
#(
  parameter logic [7:0] CHIP_ID  = 8'h08,
  parameter logic [2:0] CHILD_ID = 3'b000,
  localparam int        SW       = $clog2(NUM_CH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [7:0]           addr_i,
  input  logic [DW-1:0]        wdata_i,
  input  logic                 wr_i,
  input  logic                 rd_i,
  output logic [DW-1:0]        rdata_o,
  output logic                 lsb_first_o,
  output logic [NUM_CH*3-1:0]  pwr_mode_o,
  output logic [NUM_CH-1:0]    dcs_en_o,
  output logic [NUM_CH*DW-1:0] test_ctl_o
);
  logic          lsb_q, soft_q, xfer_q;
  logic [5:0]    idx_hi_q;
  logic [3:0]    idx_lo_q;
  logic [DW-1:0] rdata_q;

  logic [NUM_CH-1:0] mask;
  logic              any_sel;
  logic [SW-1:0]     low_idx;
  chan_cfg_t         stage_a [NUM_CH];
  chan_cfg_t         live_a  [NUM_CH];
  logic              wr_pwr, wr_clk, wr_test;

  assign mask    = {idx_hi_q, idx_lo_q};
  assign wr_pwr  = wr_i && (addr_i == A_PWR);
  assign wr_clk  = wr_i && (addr_i == A_CLK);
  assign wr_test = wr_i && (addr_i == A_TEST);

  // global registers; soft_q doubles as the pending-clear flag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lsb_q    <= 1'b0;
      soft_q   <= 1'b0;
      xfer_q   <= 1'b0;
      idx_hi_q <= 6'h0F;
      idx_lo_q <= 4'hF;
    end else if (soft_q) begin
      soft_q   <= 1'b0;
      xfer_q   <= 1'b0;
      idx_hi_q <= 6'h0F;
      idx_lo_q <= 4'hF;
    end else begin
      xfer_q <= 1'b0;
      if (wr_i) begin
        unique case (addr_i)
          A_PORT: begin
            lsb_q  <= wdata_i[6];  // upper nibble is authoritative
            soft_q <= wdata_i[5];
          end
          A_IDXHI: idx_hi_q <= wdata_i[5:0];
          A_IDXLO: idx_lo_q <= wdata_i[3:0];
          A_XFER:  xfer_q   <= wdata_i[0];
          default: ;
        endcase
      end
    end
  end

  cfg_chan_select #(.N(NUM_CH)) u_sel (
    .mask_i (mask),
    .any_o  (any_sel),
    .idx_o  (low_idx)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    cfg_chan_regs u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (soft_q),
      .sel_i     (mask[c]),
      .wr_pwr_i  (wr_pwr),
      .wr_clk_i  (wr_clk),
      .wr_test_i (wr_test),
      .wdata_i   (wdata_i),
      .xfer_i    (xfer_q),
      .stage_o   (stage_a[c]),
      .live_o    (live_a[c])
    );
    assign pwr_mode_o[3*c +: 3]  = live_a[c].pwr;
    assign dcs_en_o[c]           = live_a[c].dcs;
    assign test_ctl_o[DW*c +: DW] = live_a[c].test;
  end

  chan_cfg_t     rd_ch;
  logic [DW-1:0] rd_val;

  always_comb begin
    rd_ch  = stage_a[low_idx];
    rd_val = '0;
    unique case (addr_i)
      A_PORT:  rd_val = {1'b0, lsb_q, soft_q, 2'b11, soft_q, lsb_q, 1'b0};
      A_ID:    rd_val = CHIP_ID;
      A_GRADE: rd_val = {1'b0, CHILD_ID, 4'b0000};
      A_IDXHI: rd_val = {2'b00, idx_hi_q};
      A_IDXLO: rd_val = {4'b0000, idx_lo_q};
      A_PWR:   rd_val = any_sel ? {5'b0, rd_ch.pwr} : '0;
      A_CLK:   rd_val = any_sel ? {7'b0, rd_ch.dcs} : '0;
      A_TEST:  rd_val = any_sel ? rd_ch.test : '0;
      A_XFER:  rd_val = {7'b0, xfer_q};
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_val;
  end

  assign rdata_o     = rdata_q;
  assign lsb_first_o = lsb_q;
endmodule

// File: rtl/cfg_bank_chk.sv
module cfg_bank_chk
  import cfg_bank_pkg::*;
#(
  parameter logic [7:0] CHIP_ID = 8'h08
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [7:0]           addr_i,
  input logic [DW-1:0]        wdata_i,
  input logic                 wr_i,
  input logic                 rd_i,
  input logic [DW-1:0]        rdata_o,
  input logic [NUM_CH*3-1:0]  pwr_mode_o,
  input logic [NUM_CH-1:0]    dcs_en_o,
  input logic [NUM_CH*DW-1:0] test_ctl_o
);
  logic xfer_d, soft_d, mapped;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xfer_d <= 1'b0;
      soft_d <= 1'b0;
    end else begin
      xfer_d <= wr_i && addr_i == A_XFER && wdata_i[0];
      soft_d <= wr_i && addr_i == A_PORT && wdata_i[5];
    end
  end

  assign mapped = addr_i inside {A_PORT, A_ID, A_GRADE, A_IDXHI, A_IDXLO,
                                 A_PWR, A_CLK, A_TEST, A_XFER};

  // R5: live copies move only after a transfer or soft reset
  a_r5_live_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xfer_d && !soft_d) |=> ($stable(pwr_mode_o) && $stable(dcs_en_o) && $stable(test_ctl_o)));

  a_r2_chip_id: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == A_ID) |=> (rdata_o == CHIP_ID));

  a_r8_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !mapped) |=> (rdata_o == 8'h00));

  a_r3_port_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == A_PORT) |=> (rdata_o[4:3] == 2'b11 && !rdata_o[7] && !rdata_o[0]
                                    && rdata_o[6] == rdata_o[1] && rdata_o[5] == rdata_o[2]));

  a_r9_soft_defaults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_d |=> (pwr_mode_o == '0 && dcs_en_o == '1 && test_ctl_o == '0));
endmodule

bind cfg_bank cfg_bank_chk #(.CHIP_ID(CHIP_ID)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .wr_i       (wr_i),
  .rd_i       (rd_i),
  .rdata_o    (rdata_o),
  .pwr_mode_o (pwr_mode_o),
  .dcs_en_o   (dcs_en_o),
  .test_ctl_o (test_ctl_o)
);

// File: tb/tb_cfg_bank.sv
`timescale 1ns/1ps
module tb_cfg_bank;
  localparam int NCH = 10;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [7:0]     addr = '0, wdata = '0, rdata;
  logic           wr = 1'b0, rd = 1'b0, lsb_first;
  logic [NCH*3-1:0] pwr_mode;
  logic [NCH-1:0]   dcs_en;
  logic [NCH*8-1:0] test_ctl;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  logic [2:0] e_pwr  [NCH];
  logic       e_dcs  [NCH];
  logic [7:0] e_test [NCH];

  always #4 clk = ~clk;

  cfg_bank dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .lsb_first_o(lsb_first),
    .pwr_mode_o(pwr_mode), .dcs_en_o(dcs_en), .test_ctl_o(test_ctl)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h exp %0h", tag, act, exp);
    end
  endtask

  // called at a negedge, returns at the next negedge
  task automatic wr_reg(logic [7:0] a, logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(logic [7:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic chk_rd(string tag, logic [7:0] a, logic [7:0] exp);
    logic [7:0] d;
    rd_reg(a, d);
    chk(tag, d, exp);
  endtask

  task automatic chk_live(string tag);
    for (int c = 0; c < NCH; c++) begin
      chk({tag, " pwr"},  pwr_mode[3*c +: 3], e_pwr[c]);
      chk({tag, " dcs"},  dcs_en[c],          e_dcs[c]);
      chk({tag, " test"}, test_ctl[8*c +: 8], e_test[c]);
    end
  endtask

  task automatic set_defaults();
    for (int c = 0; c < NCH; c++) begin
      e_pwr[c] = 3'd0; e_dcs[c] = 1'b1; e_test[c] = 8'h00;
    end
  endtask

  task automatic select(logic [9:0] m);
    wr_reg(8'h05, {4'h0, m[3:0]});
    wr_reg(8'h04, {2'b00, m[9:4]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] exp_port;
    set_defaults();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 defaults
    chk_rd("R1 port", 8'h00, 8'h18);
    chk_rd("R1 idxhi", 8'h04, 8'h0F);
    chk_rd("R1 idxlo", 8'h05, 8'h0F);
    chk_rd("R1 pwr", 8'h08, 8'h00);
    chk_rd("R1 clk", 8'h09, 8'h01);
    chk_rd("R1 test", 8'h0D, 8'h00);
    chk_rd("R1 xfer", 8'hFF, 8'h00);
    chk_live("R1 live");
    chk("R1 lsb", lsb_first, 1'b0);

    // R2 identification, read-only
    chk_rd("R2 id", 8'h01, 8'h08);
    chk_rd("R2 grade", 8'h02, 8'h00);
    wr_reg(8'h01, 8'h55);
    wr_reg(8'h02, 8'h70);
    chk_rd("R2 id after write", 8'h01, 8'h08);
    chk_rd("R2 grade after write", 8'h02, 8'h00);

    // R8 sweep of every address
    for (int a = 0; a < 256; a++) begin
      if (!(a inside {8'h00, 8'h01, 8'h02, 8'h04, 8'h05, 8'h08, 8'h09, 8'h0D, 8'hFF}))
        chk_rd("R8 unmapped", 8'(a), 8'h00);
    end

    // R3 mirroring over all bytes without the soft-reset bit
    for (int v = 0; v < 256; v++) begin
      if (v[5] == 1'b0) begin
        wr_reg(8'h00, 8'(v));
        exp_port = {1'b0, v[6], 1'b0, 2'b11, 1'b0, v[6], 1'b0};
        chk_rd("R3 port", 8'h00, exp_port);
        chk("R3 lsb_first", lsb_first, v[6]);
      end
    end
    wr_reg(8'h00, 8'h00);

    // R4 R5 R7: stage a distinct value per channel
    for (int c = 0; c < NCH; c++) begin
      select(10'(1 << c));
      wr_reg(8'h0D, 8'(8'h30 + c));
      wr_reg(8'h08, 8'(c % 8));
      wr_reg(8'h09, 8'(c & 1));
      chk_rd("R7 test single", 8'h0D, 8'(8'h30 + c));
      chk_rd("R7 pwr single", 8'h08, 8'(c % 8));
      chk_rd("R7 clk single", 8'h09, 8'(c & 1));
    end
    select(10'h2A5);
    chk_rd("R4 idxhi", 8'h04, 8'h2A);
    chk_rd("R4 idxlo", 8'h05, 8'h05);
    chk_live("R5 live unchanged");
    select(10'h3FF);
    chk_rd("R7 lowest all", 8'h0D, 8'h30);
    select(10'h220);
    chk_rd("R7 lowest F,dclk", 8'h0D, 8'h35);
    select(10'h200);
    chk_rd("R7 dclk only", 8'h08, 8'h01);
    select(10'h000);
    chk_rd("R7 none", 8'h0D, 8'h00);

    // R6 transfer
    wr_reg(8'hFF, 8'h01);
    chk_rd("R6 pending", 8'hFF, 8'h01);
    for (int c = 0; c < NCH; c++) begin
      e_test[c] = 8'(8'h30 + c); e_pwr[c] = 3'(c % 8); e_dcs[c] = c[0];
    end
    chk_live("R11 live after transfer");
    chk_rd("R6 self-clear", 8'hFF, 8'h00);

    // R6 bit 0 clear has no effect; R5 fan-out stays in staging
    select(10'h3FF);
    wr_reg(8'h0D, 8'hAA);
    wr_reg(8'hFF, 8'hFE);
    @(negedge clk);
    @(negedge clk);
    chk_live("R6 no transfer");
    chk_rd("R6 reads zero", 8'hFF, 8'h00);

    // R10 write in the copy cycle
    select(10'h001);
    wr_reg(8'h0D, 8'h11);
    wr_reg(8'hFF, 8'h01);
    wr_reg(8'h0D, 8'h22);
    e_test[0] = 8'h11;
    for (int c = 1; c < NCH; c++) e_test[c] = 8'hAA;
    chk_live("R10 old staged value live");
    chk_rd("R10 staged new", 8'h0D, 8'h22);
    wr_reg(8'hFF, 8'h01);
    @(negedge clk);
    e_test[0] = 8'h22;
    chk_live("R10 second transfer");

    // R9 soft reset keeps bit order
    wr_reg(8'h00, 8'h60);
    chk_rd("R9 pending", 8'h00, 8'h7E);
    set_defaults();
    chk_live("R9 live defaults");
    chk_rd("R9 port kept lsb", 8'h00, 8'h5A);
    chk("R9 lsb_first", lsb_first, 1'b1);
    chk_rd("R9 idxhi", 8'h04, 8'h0F);
    chk_rd("R9 idxlo", 8'h05, 8'h0F);
    chk_rd("R9 test", 8'h0D, 8'h00);
    chk_rd("R9 clk", 8'h09, 8'h01);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule